// File: doc/BRIEF.md
# Fractional Clock-Enable Divider

This block generates a one-cycle clock-enable pulse for an engine that runs slower than the system clock. The rate is set by a fixed-point divisor with a 16-bit integer part and an 8-bit fraction. Over time, the enable is high once every *divisor* system cycles on average. The integer part sets the base length of each period. An 8-bit fractional accumulator adds one extra cycle to a period whenever its sum carries out.

A restart strobe resets the phase of the divider. When several instances are restarted in the same cycle, they produce identical enable patterns from then on. A new divisor is written through a 32-bit data word and a write strobe. The new value is used from the next period boundary or the next restart, so the period already running is never cut short or stretched.

Top module: `frac_clk_en_div`

## Requirements
- R1: After reset, the divisor is 1.0 and `clk_en` is high in every cycle.
- R2: In the divisor word, bits 31:16 are the integer part and bits 15:8 are the fraction. Bits 7:0 have no effect on the enable pattern.
- R3: With a divisor of 1.0, `clk_en` is high in every cycle.
- R4: With an integer part N and a fraction of 0, the first pulse is in cycle N-1 after the restart edge, counting the cycle right after that edge as cycle 0. After that, pulses come every N cycles.
- R5: An integer part of 0 selects a period of 65536 cycles, so the first pulse after a restart is in cycle 65535.
- R6: At each pulse, the 8-bit accumulator adds the fraction. The following period is the integer length plus one extra cycle when that addition carries out of 8 bits.
- R7: A restart clears the accumulator. It starts a fresh period of the integer length, using the newest divisor, from any phase.
- R8: A divisor written in the middle of a period leaves that period unchanged. It takes effect at the next pulse, and a write in the same cycle as a pulse or a restart applies at once.
- R9: Two dividers with the same divisor that are restarted in the same cycle produce identical `clk_en` sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_we | input | 1 | Write strobe for the divisor word |
| div_wdata | input | 32 | Divisor word: integer part in bits 31:16, fraction in bits 15:8 |
| restart | input | 1 | Phase restart strobe |
| clk_en | output | 1 | One-cycle enable pulse |

## Verification
The assertions check on every cycle that:
- the period counter counts down by one between pulses and never reaches zero;
- the accumulator stays frozen within a period;
- a restart clears the accumulator;
- a restart with a 1.0 divisor gives an immediate pulse;
- a restart with an integer part of 0 loads the 65536-cycle length;
- the selected divisor changes only on a write.

Only the bench scenarios can show the following:
- the exact pulse positions for fractional divisors over many periods;
- that the low byte of the divisor word is ignored;
- when a write made mid-period takes effect;
- that two restarted instances stay in lockstep.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

    // Action taken by the period counter in the current cycle
    typedef enum logic [1:0] {
        ACT_COUNT   = 2'd0,
        ACT_WRAP    = 2'd1,
        ACT_RESTART = 2'd2
    } div_act_e;

endpackage

// File: rtl/frac_div_cfg.sv
module frac_div_cfg #(
    parameter int REG_W  = 32,
    parameter int INT_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [INT_W-1:0]  sel_int,
    output logic [FRAC_W-1:0] sel_frac
);
    localparam int INT_LSB  = REG_W - INT_W;
    localparam int FRAC_LSB = INT_LSB - FRAC_W;

    typedef struct packed {
        logic [INT_W-1:0]  ipart;
        logic [FRAC_W-1:0] fpart;
    } shadow_t;

    shadow_t shadow_q, shadow_d;
    shadow_t incoming;

    always_comb begin
        incoming.ipart = wr_data[REG_W-1:INT_LSB];
        incoming.fpart = wr_data[INT_LSB-1:FRAC_LSB];
        shadow_d       = wr_en ? incoming : shadow_q;
        // A write in this cycle is visible to a boundary in the same cycle
        sel_int        = shadow_d.ipart;
        sel_frac       = shadow_d.fpart;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q.ipart <= INT_W'(1);
            shadow_q.fpart <= '0;
        end else begin
            shadow_q <= shadow_d;
        end
    end

    // R8
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (wr_en || ($stable(sel_int) && $stable(sel_frac))));

endmodule

// File: rtl/frac_div_core.sv
module frac_div_core
    import frac_div_pkg::*;
#(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [INT_W-1:0]  sel_int,
    input  logic [FRAC_W-1:0] sel_frac,
    output logic              clk_en
);
    localparam int CNT_W = INT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [FRAC_W-1:0] acc;
    } core_st_t;

    core_st_t          st_q, st_d;
    div_act_e          act;
    logic [CNT_W-1:0]  base_len;
    logic [FRAC_W:0]   acc_sum;

    always_comb begin
        // Integer part 0 stands for 2**INT_W
        base_len = (sel_int == '0) ? (CNT_W'(1) << INT_W) : {1'b0, sel_int};
        acc_sum  = {1'b0, st_q.acc} + {1'b0, sel_frac};

        if (restart)                     act = ACT_RESTART;
        else if (st_q.cnt == CNT_W'(1))  act = ACT_WRAP;
        else                             act = ACT_COUNT;

        st_d = st_q;
        case (act)
            ACT_RESTART: begin
                st_d.cnt = base_len;
                st_d.acc = '0;
            end
            ACT_WRAP: begin
                st_d.acc = acc_sum[FRAC_W-1:0];
                st_d.cnt = base_len + CNT_W'(acc_sum[FRAC_W]);
            end
            default: begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= CNT_W'(1);
            st_q.acc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_en = (st_q.cnt == CNT_W'(1));

    // R4
    always_comb begin
        if (rst_n) begin
            cnt_nonzero_chk: assert (st_q.cnt != '0);
        end
    end

    // R4
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !clk_en) |=> (st_q.cnt == $past(st_q.cnt) - CNT_W'(1)));

    // R6
    acc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !clk_en) |=> $stable(st_q.acc));

    // R7
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.acc == '0));

    // R3
    unity_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && sel_int == INT_W'(1)) |=> clk_en);

    // R5
    max_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && sel_int == '0) |=> (st_q.cnt[INT_W] && st_q.cnt[INT_W-1:0] == '0));

endmodule

// File: rtl/frac_clk_en_div.sv
module frac_clk_en_div #(
    parameter int REG_W  = 32,
    parameter int INT_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_we,
    input  logic [REG_W-1:0] div_wdata,
    input  logic             restart,
    output logic             clk_en
);
    logic [INT_W-1:0]  sel_int;
    logic [FRAC_W-1:0] sel_frac;

    frac_div_cfg #(
        .REG_W  (REG_W),
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (div_we),
        .wr_data  (div_wdata),
        .sel_int  (sel_int),
        .sel_frac (sel_frac)
    );

    frac_div_core #(
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .sel_int  (sel_int),
        .sel_frac (sel_frac),
        .clk_en   (clk_en)
    );

endmodule

// File: tb/tb_frac_clk_en_div.sv
`timescale 1ns/1ps
module tb_frac_clk_en_div;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_we = 1'b0;
    logic [31:0] div_wdata = '0;
    logic        restart = 1'b0;
    logic        restart_b = 1'b0;
    logic        clk_en;
    logic        clk_en_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    frac_clk_en_div dut (
        .clk(clk), .rst_n(rst_n), .div_we(div_we), .div_wdata(div_wdata),
        .restart(restart), .clk_en(clk_en)
    );

    frac_clk_en_div dut_b (
        .clk(clk), .rst_n(rst_n), .div_we(div_we), .div_wdata(div_wdata),
        .restart(restart_b), .clk_en(clk_en_b)
    );

    task automatic check(input string req, input logic act, input logic exp, input int cyc);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: clk_en actual=%0b expected=%0b", req, cyc, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input int ip, input int fp, input int low);
        return {ip[15:0], fp[7:0], low[7:0]};
    endfunction

    // R1 R3: reset value 1.0 gives a pulse every cycle
    task automatic t_reset();
        for (int c = 0; c < 8; c++) begin
            check("R1", clk_en, 1'b1, c);
            @(negedge clk);
        end
    endtask

    // Write and restart together, then compare against the period rule
    task automatic t_pattern(input string req, input int ip, input int fp, input int low, input int n);
        int m_cnt;
        int m_acc;
        int len;
        len = (ip == 0) ? 65536 : ip;
        div_we = 1'b1; div_wdata = word(ip, fp, low); restart = 1'b1;
        @(negedge clk);
        div_we = 1'b0; restart = 1'b0;
        m_cnt = len; m_acc = 0;
        for (int c = 0; c < n; c++) begin
            check(req, clk_en, (m_cnt == 1), c);
            if (m_cnt == 1) begin
                m_acc = m_acc + fp;
                m_cnt = len + (m_acc >= 256 ? 1 : 0);
                m_acc = m_acc % 256;
            end else begin
                m_cnt = m_cnt - 1;
            end
            @(negedge clk);
        end
    endtask

    // R5: integer 0 means 65536 cycles
    task automatic t_max();
        int early = 0;
        div_we = 1'b1; div_wdata = word(0, 0, 0); restart = 1'b1;
        @(negedge clk);
        div_we = 1'b0; restart = 1'b0;
        for (int c = 0; c < 65535; c++) begin
            if (clk_en) early++;
            @(negedge clk);
        end
        checks++;
        if (early != 0) begin
            errors++;
            $display("FAIL R5: pulses before cycle 65535 actual=%0d expected=0", early);
        end
        check("R5", clk_en, 1'b1, 65535);
        @(negedge clk);
        check("R5", clk_en, 1'b0, 65536);
    endtask

    // R8: mid-period write leaves the running period alone
    task automatic t_update();
        div_we = 1'b1; div_wdata = word(10, 0, 0); restart = 1'b1;
        @(negedge clk);
        div_we = 1'b0; restart = 1'b0;
        for (int c = 0; c < 21; c++) begin
            check("R8", clk_en, (c == 9 || c == 13 || c == 17), c);
            if (c == 3) begin
                div_we = 1'b1; div_wdata = word(4, 0, 0);
            end else begin
                div_we = 1'b0;
            end
            @(negedge clk);
        end
        div_we = 1'b0;
    endtask

    // R9: common restart aligns two instances
    task automatic t_lockstep();
        div_we = 1'b1; div_wdata = word(3, 8'h55, 0); restart = 1'b1;
        @(negedge clk);
        div_we = 1'b0; restart = 1'b0;
        @(negedge clk);
        restart = 1'b1; restart_b = 1'b1;
        @(negedge clk);
        restart = 1'b0; restart_b = 1'b0;
        for (int c = 0; c < 40; c++) begin
            check("R9", clk_en_b, clk_en, c);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pattern("R3", 1, 0, 0, 10);
        t_pattern("R4", 3, 0, 0, 30);
        t_pattern("R4", 7, 0, 0, 30);
        t_pattern("R6", 2, 8'h80, 0, 60);
        t_pattern("R6", 1, 8'h40, 0, 60);
        t_pattern("R2", 5, 8'h33, 8'hFF, 120);
        // Restart in the middle of a running fractional period
        t_pattern("R7", 4, 8'hC0, 0, 7);
        t_pattern("R7", 4, 8'hC0, 0, 50);
        t_update();
        t_lockstep();
        t_max();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule